// File: doc/BRIEF.md
# Slot Interrupt Router

This block sits between the PCI slots of a board and a host bridge's interrupt input. Each request names its source by slot number and PCI interrupt pin (0 to 3). The slot number is the device number, which is bits [7:3] of the device/function code. A fixed routing table for the board turns the slot and pin into an internal bridge interrupt number. Numbers from 32 upward are the bridge's own lines.

The block then drives one interrupt line towards the processor. The line index is the routed number minus 32. That index picks one bit from a 32-bit trigger-mode word and one bit from a 32-bit polarity word. A line set to pulse mode produces a single-cycle pulse. A line set to level mode drives the processor line to its polarity bit, and the line keeps that value until the next routed request.

A request from a slot outside the table is passed through as its raw pin number and leaves the processor line untouched.

Top module: `slot_irq_router`

## Requirements
- R1: For slot 5, `irq_num` equals 32 + pin (pin taken modulo 4), combinationally from the inputs.
- R2: Slot 6 gives `irq_num` = 36 and slot 7 gives `irq_num` = 37, whatever the pin.
- R3: Slots 8 to 12 give `irq_num` = 38 + (slot − 8) + pin, so slot 12 pin 3 gives 45.
- R4: Any other slot gives `irq_num` equal to the pin number, and a request from such a slot leaves `cpu_irq` unchanged.
- R5: A routed request uses line index `irq_num` − 32, and only bit [index] of `edge_sel` and bit [index] of `pol_sel` affect its result.
- R6: When `edge_sel[index]` is 1, `cpu_irq` is 1 in the cycle after the request clock edge and returns to 0 one cycle later, unless another routed request arrives.
- R7: When `edge_sel[index]` is 0, `cpu_irq` takes the value of `pol_sel[index]` in the cycle after the request clock edge and holds it until the next routed request.
- R8: While `rst_n` is low, and after reset, `cpu_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A request is presented this cycle |
| evt_slot | input | 5 | Slot (device) number, device/function code bits [7:3] |
| evt_pin | input | 2 | PCI interrupt pin 0 to 3 |
| edge_sel | input | 32 | Per-line trigger mode: 1 selects pulse, 0 selects level |
| pol_sel | input | 32 | Per-line level value used in level mode |
| irq_num | output | 8 | Routed interrupt number for the presented slot and pin |
| cpu_irq | output | 1 | Interrupt line to the processor |

## Verification
The hardest case to bring about is proving that a request selects its own line's configuration bits and not a neighbour's. Done carelessly, a wrong index looks the same as a right one. The stimulus therefore sets configuration words in which the requested line and its neighbours have opposite trigger mode and polarity bits. A wrong index then shows up as a pulse where a held level is expected, or a low where a high is expected. A second case is a level that is held across an untranslated request. To reach it, the bench first raises the line through a level-mode slot, then sends a request from a slot outside the table and watches the line for several cycles.

// File: rtl/slot_irq_router.sv
module slot_irq_router #(
  parameter int IRQ_BASE = 32,
  parameter int LINES    = 32,
  parameter int SLOT_W   = 5,
  parameter int PIN_W    = 2,
  parameter int NUM_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [SLOT_W-1:0] evt_slot,
  input  logic [PIN_W-1:0]  evt_pin,
  input  logic [LINES-1:0]  edge_sel,
  input  logic [LINES-1:0]  pol_sel,
  output logic [NUM_W-1:0]  irq_num,
  output logic              cpu_irq
);
  localparam int LINE_W = $clog2(LINES);

  logic [NUM_W-1:0]  num;
  logic              routed;
  logic [LINE_W-1:0] line;
  logic              pulse_q;

  always_comb begin
    routed = 1'b1;
    case (evt_slot)
      SLOT_W'(5): num = NUM_W'(IRQ_BASE) + NUM_W'(evt_pin);
      SLOT_W'(6): num = NUM_W'(IRQ_BASE + 4);
      SLOT_W'(7): num = NUM_W'(IRQ_BASE + 5);
      SLOT_W'(8), SLOT_W'(9), SLOT_W'(10), SLOT_W'(11), SLOT_W'(12):
        num = NUM_W'(IRQ_BASE + 6) + NUM_W'(evt_slot - SLOT_W'(8)) + NUM_W'(evt_pin);
      default: begin
        num    = NUM_W'(evt_pin);
        routed = 1'b0;
      end
    endcase
  end

  assign irq_num = num;
  assign line    = LINE_W'(num - NUM_W'(IRQ_BASE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_irq <= 1'b0;
      pulse_q <= 1'b0;
    end else if (evt_valid && routed) begin
      cpu_irq <= edge_sel[line] ? 1'b1 : pol_sel[line];
      pulse_q <= edge_sel[line];
    end else if (pulse_q) begin
      cpu_irq <= 1'b0;
      pulse_q <= 1'b0;
    end
  end
endmodule

module slot_irq_router_chk #(
  parameter int IRQ_BASE = 32,
  parameter int LINES    = 32,
  parameter int SLOT_W   = 5,
  parameter int PIN_W    = 2,
  parameter int NUM_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic [SLOT_W-1:0] evt_slot,
  input logic [PIN_W-1:0]  evt_pin,
  input logic [LINES-1:0]  edge_sel,
  input logic [LINES-1:0]  pol_sel,
  input logic [NUM_W-1:0]  irq_num,
  input logic              cpu_irq
);
  localparam int LINE_W = $clog2(LINES);

  logic              in_table;
  logic [LINE_W-1:0] idx;
  logic              hit_edge;
  logic              hit_level;
  logic              lvl_val;

  assign in_table  = (evt_slot >= SLOT_W'(5)) && (evt_slot <= SLOT_W'(12));
  assign idx       = LINE_W'(irq_num - NUM_W'(IRQ_BASE));
  assign hit_edge  = evt_valid && in_table && edge_sel[idx];
  assign hit_level = evt_valid && in_table && !edge_sel[idx];
  assign lvl_val   = pol_sel[idx];

  always_comb begin
    if (evt_slot == SLOT_W'(6)) AST_SLOT6_FIXED: assert (irq_num == NUM_W'(IRQ_BASE + 4)); // R2
    if (evt_slot == SLOT_W'(5)) AST_SLOT5_PIN: assert (irq_num == NUM_W'(IRQ_BASE) + NUM_W'(evt_pin)); // R1
    if (!in_table) AST_PASS_THROUGH: assert (irq_num == NUM_W'(evt_pin)); // R4
  end

  AST_PULSE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_edge |=> cpu_irq); // R6
  AST_PULSE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_edge ##1 !(evt_valid && in_table)) |=> !cpu_irq); // R6
  AST_LEVEL_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_level |=> (cpu_irq == $past(lvl_val))); // R7
  AST_IDLE_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!(evt_valid && in_table) && !cpu_irq) |=> !cpu_irq); // R4
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> !cpu_irq); // R8
endmodule

bind slot_irq_router slot_irq_router_chk #(
  .IRQ_BASE(IRQ_BASE), .LINES(LINES), .SLOT_W(SLOT_W), .PIN_W(PIN_W), .NUM_W(NUM_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_slot(evt_slot),
  .evt_pin(evt_pin), .edge_sel(edge_sel), .pol_sel(pol_sel),
  .irq_num(irq_num), .cpu_irq(cpu_irq)
);

// File: tb/slot_irq_router_tb.sv
module slot_irq_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [4:0]  evt_slot = '0;
  logic [1:0]  evt_pin = '0;
  logic [31:0] edge_sel = '0;
  logic [31:0] pol_sel = '0;
  logic [7:0]  irq_num;
  logic        cpu_irq;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  slot_irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_slot(evt_slot),
    .evt_pin(evt_pin), .edge_sel(edge_sel), .pol_sel(pol_sel),
    .irq_num(irq_num), .cpu_irq(cpu_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic map_check(input string req, input int slot, input int pin, input int exp);
    @(negedge clk);
    evt_slot = 5'(slot);
    evt_pin  = 2'(pin);
    #1;
    check(req, int'(irq_num), exp);
  endtask

  // present a request for one clock edge; returns at the negedge after it
  task automatic fire(input int slot, input int pin);
    @(negedge clk);
    evt_slot  = 5'(slot);
    evt_pin   = 2'(pin);
    evt_valid = 1'b1;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R8 reset low", int'(cpu_irq), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after reset", int'(cpu_irq), 0);
  endtask

  task automatic t_mapping;
    for (int p = 0; p < 4; p++) map_check("R1 slot5", 5, p, 32 + p);
    map_check("R2 slot6", 6, 2, 36);
    map_check("R2 slot7", 7, 1, 37);
    map_check("R3 slot8 pin0", 8, 0, 38);
    map_check("R3 slot10 pin1", 10, 1, 41);
    map_check("R3 slot12 pin3", 12, 3, 45);
    map_check("R4 slot0", 0, 2, 2);
    map_check("R4 slot31", 31, 3, 3);
    map_check("R4 slot4", 4, 1, 1);
  endtask

  task automatic t_level;
    edge_sel = 32'hFFFF_FFCF;        // lines 4,5 level, neighbours pulse
    pol_sel  = 32'h0000_0010;        // only line 4 high
    fire(6, 0);
    check("R7 level high", int'(cpu_irq), 1);
    repeat (3) @(negedge clk);
    check("R7 level held", int'(cpu_irq), 1);
    fire(3, 1);
    repeat (2) @(negedge clk);
    check("R4 untranslated keeps level", int'(cpu_irq), 1);
    fire(7, 0);
    check("R5 line5 polarity low", int'(cpu_irq), 0);
    repeat (2) @(negedge clk);
    check("R7 low held", int'(cpu_irq), 0);
  endtask

  task automatic t_pulse;
    edge_sel = 32'h0000_2000;        // only line 13 pulses
    pol_sel  = 32'h0000_0000;
    fire(12, 3);
    check("R6 pulse high", int'(cpu_irq), 1);
    @(negedge clk);
    check("R6 pulse ends", int'(cpu_irq), 0);
    repeat (2) @(negedge clk);
    check("R6 stays low", int'(cpu_irq), 0);
    fire(0, 3);
    check("R4 untranslated no pulse", int'(cpu_irq), 0);
  endtask

  task automatic t_index;
    edge_sel = 32'h0000_0005;        // lines 0,2 pulse; line 1 level
    pol_sel  = 32'h0000_0002;        // line 1 high
    fire(5, 1);
    @(negedge clk);
    check("R5 line1 level not pulse", int'(cpu_irq), 1);
    edge_sel = 32'hFFFF_FFFF;
    pol_sel  = 32'h0;
    fire(9, 0);                      // line 7 pulse
    check("R6 pulse from level", int'(cpu_irq), 1);
    @(negedge clk);
    check("R6 pulse drop", int'(cpu_irq), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_mapping();
    t_level();
    t_pulse();
    t_index();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule